// File: doc/BRIEF.md
# RGB Float to Packed 11-11-10 Small-Float Converter

This block takes one colour sample as three IEEE-754 single-precision values (red, green and blue) and turns it into one 32-bit word. The word holds three unsigned small floats. Each channel is reduced on its own path: the value is truncated toward zero, its exponent is rebased, and it is placed in a fixed bit field. The three fields are then merged with a bitwise OR.

A single register stage captures the packed word whenever the input valid strobe is high. The output valid strobe repeats the input strobe one cycle later. Render-target write paths and texture-store paths use the block to write an HDR colour into a compact 32-bit slot.

Every field uses a 5-bit exponent with a bias of 15. There is no sign bit and no rounding. Negative inputs collapse to zero. Infinity and NaN keep their special encodings.

Top module: `rgb_f32_to_r11g11b10_pack`

## Requirements
- R1: Red is encoded with a 5-bit exponent (bias 15) above a 6-bit mantissa in `out_word[10:0]`, as the largest code whose value does not exceed the input (truncation toward zero).
- R2: Green uses the same 5+6 encoding and truncation as red, placed in `out_word[21:11]`.
- R3: Blue is encoded with a 5-bit exponent (bias 15) above a 5-bit mantissa in `out_word[31:22]`, truncated toward zero.
- R4: A finite positive input at or above a channel's largest finite value gives exponent 30 (binary 11110) with an all-ones mantissa. A finite input never yields the all-ones exponent.
- R5: A negative finite input, negative zero or negative infinity gives an all-zero field.
- R6: Positive infinity gives the all-ones exponent with a zero mantissa.
- R7: A NaN of either sign gives the all-ones exponent, the mantissa MSB set and every other mantissa bit clear.
- R8: A positive input below 2^-14 gives exponent 0 and mantissa floor(x * 2^(14+M)), where M is the channel's mantissa width. Single-precision denormals give 0. No field ever sets a bit outside its own range.
- R9: `out_valid` equals `in_valid` delayed by one clock. While `rst_n` is low, `out_valid` and `out_word` are 0.
- R10: `out_word` loads the packed result only on a clock where `in_valid` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample strobe |
| in_red | input | 32 | Red component, single precision |
| in_green | input | 32 | Green component, single precision |
| in_blue | input | 32 | Blue component, single precision |
| out_valid | output | 1 | Packed word strobe, one cycle after `in_valid` |
| out_word | output | 32 | Packed blue/green/red small-float word |

## Verification
The sweep takes every single-precision exponent code with both signs and with mantissas that are zero, one LSB, the top bit only, all ones and two mixed patterns. The three channels receive different inputs in the same word.

Each region tests something different:
- Codes near the top of the range separate correct saturation from wrap-around or an infinity leaking out.
- Codes just below the smallest normal show whether the denormal shift is right and whether stray bits stay inside their field.
- The all-ones exponent with zero and non-zero mantissas separates infinity from NaN for each sign.
- The mixed mantissas expose truncation that rounds instead.

Idle cycles with changed input data show that the register holds its value.

// File: rtl/rgbpk_pkg.sv
package rgbpk_pkg;

  localparam int F32_EXP_W = 8;
  localparam int F32_MAN_W = 23;
  localparam int F32_BIAS  = 127;
  localparam int WORD_W    = 32;
  localparam int NUM_CH    = 3;

  typedef struct packed {
    logic                 sign;
    logic [F32_EXP_W-1:0] exp;
    logic [F32_MAN_W-1:0] man;
  } f32_t;

  // per-channel layout: index 0 red, 1 green, 2 blue
  function automatic int ch_man_w(input int ch);
    return (ch == 2) ? 5 : 6;
  endfunction

  function automatic int ch_exp_w(input int ch);
    return (ch < 0) ? 0 : 5;
  endfunction

  function automatic int ch_lsb(input int ch);
    return (ch == 0) ? 0 : (ch == 1) ? 11 : 22;
  endfunction

endpackage

// File: rtl/ufloat_chan_cvt.sv
module ufloat_chan_cvt
  import rgbpk_pkg::*;
#(
  parameter int MAN_W = 6,
  parameter int EXP_W = 5
) (
  input  f32_t                   src,
  output logic [EXP_W+MAN_W-1:0] code
);

  localparam int FW          = EXP_W + MAN_W;
  localparam int BIAS        = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX     = (1 << EXP_W) - 1;
  localparam int REBASE      = F32_BIAS - BIAS;
  localparam int NORM_MIN_E8 = REBASE + 1;
  localparam int OVF_E8      = REBASE + EXP_MAX;
  localparam int DEN_K       = F32_BIAS + F32_MAN_W - BIAS + 1 - MAN_W;

  logic is_nan;
  logic is_inf;
  logic [F32_EXP_W-1:0] den_sh;

  assign is_nan = (src.exp == {F32_EXP_W{1'b1}}) && (src.man != '0);
  assign is_inf = (src.exp == {F32_EXP_W{1'b1}}) && (src.man == '0);
  assign den_sh = F32_EXP_W'(DEN_K) - src.exp;

  always_comb begin
    code = '0;
    if (is_nan) begin
      code = {EXP_W'(EXP_MAX), 1'b1, {(MAN_W-1){1'b0}}};
    end else if (src.sign) begin
      code = '0;
    end else if (is_inf) begin
      code = {EXP_W'(EXP_MAX), {MAN_W{1'b0}}};
    end else if (int'(src.exp) >= OVF_E8) begin
      code = {EXP_W'(EXP_MAX - 1), {MAN_W{1'b1}}};
    end else if (int'(src.exp) >= NORM_MIN_E8) begin
      code = {EXP_W'(src.exp - F32_EXP_W'(REBASE)),
              src.man[F32_MAN_W-1 -: MAN_W]};
    end else if (src.exp != '0) begin
      code = FW'({1'b1, src.man} >> den_sh);
    end
  end

endmodule

// File: rtl/rgb_f32_to_r11g11b10_pack.sv
module rgb_f32_to_r11g11b10_pack
  import rgbpk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_red,
  input  logic [31:0] in_green,
  input  logic [31:0] in_blue,
  output logic        out_valid,
  output logic [31:0] out_word
);

  logic [WORD_W-1:0] chan_in [NUM_CH];
  logic [WORD_W-1:0] placed  [NUM_CH];
  logic [WORD_W-1:0] packed_w;

  assign chan_in[0] = in_red;
  assign chan_in[1] = in_green;
  assign chan_in[2] = in_blue;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int MW  = ch_man_w(ch);
    localparam int EW  = ch_exp_w(ch);
    localparam int FW  = MW + EW;
    localparam int LSB = ch_lsb(ch);

    f32_t          src;
    logic [FW-1:0] fld;

    assign src = chan_in[ch];

    ufloat_chan_cvt #(
      .MAN_W (MW),
      .EXP_W (EW)
    ) u_cvt (
      .src  (src),
      .code (fld)
    );

    assign placed[ch] = WORD_W'(fld) << LSB;
  end

  always_comb begin
    packed_w = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      packed_w = packed_w | placed[ch];
    end
  end

  // next-state
  logic [WORD_W-1:0] word_d, word_q;
  logic              vld_d, vld_q;

  always_comb begin
    vld_d  = in_valid;
    word_d = word_q;
    if (in_valid) begin
      word_d = packed_w;
    end
  end

  // state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      word_q <= '0;
    end else begin
      vld_q  <= vld_d;
      word_q <= word_d;
    end
  end

  assign out_valid = vld_q;
  assign out_word  = word_q;

  // assertions
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_VALID_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word)); // R10
  AST_RED_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_red[31] && !(in_red[30:23] == 8'hff && in_red[22:0] != '0))
    |=> (out_word[10:0] == 11'd0)); // R5
  AST_BLUE_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_blue[30:23] == 8'hff && in_blue[22:0] != '0)
    |=> (out_word[31:22] == 10'b11111_10000)); // R7
  AST_GREEN_NO_ALLONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_green[30:23] != 8'hff)
    |=> (out_word[21:17] != 5'h1f)); // R4

endmodule

// File: tb/rgb_f32_to_r11g11b10_pack_test.sv
module rgb_f32_to_r11g11b10_pack_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_red = '0, in_green = '0, in_blue = '0;
  logic        out_valid;
  logic [31:0] out_word;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  rgb_f32_to_r11g11b10_pack uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_red(in_red), .in_green(in_green), .in_blue(in_blue),
    .out_valid(out_valid), .out_word(out_word)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic real f32_val(input logic [31:0] b);
    int e8 = int'(b[30:23]);
    int m  = int'(b[22:0]);
    if (e8 == 0) return real'(m) * (2.0 ** (-149));
    return real'(8388608 + m) * (2.0 ** (e8 - 150));
  endfunction

  function automatic real sf_val(input int code, input int mw);
    int e = code >> mw;
    int m = code & ((1 << mw) - 1);
    if (e == 0) return real'(m) * (2.0 ** (-14 - mw));
    return real'((1 << mw) + m) * (2.0 ** (e - 15 - mw));
  endfunction

  function automatic int exp_code(input logic [31:0] b, input int mw);
    real x;
    int lo, hi, mid;
    if (b[30:23] == 8'hff && b[22:0] != 0) return (31 << mw) | (1 << (mw - 1));
    if (b[31]) return 0;
    if (b[30:23] == 8'hff) return 31 << mw;
    x  = f32_val(b);
    hi = (30 << mw) | ((1 << mw) - 1);
    if (sf_val(hi, mw) <= x) return hi;
    lo = 0;
    while (hi - lo > 1) begin
      mid = (lo + hi) / 2;
      if (sf_val(mid, mw) <= x) lo = mid; else hi = mid;
    end
    return lo;
  endfunction

  function automatic string tag_for(input logic [31:0] b, input int mw, input string base);
    if (b[30:23] == 8'hff && b[22:0] != 0) return "R7";
    if (b[31]) return "R5";
    if (b[30:23] == 8'hff) return "R6";
    if (f32_val(b) >= sf_val((30 << mw) | ((1 << mw) - 1), mw)) return "R4";
    if (f32_val(b) < (2.0 ** (-14))) return "R8";
    return base;
  endfunction

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [22:0] man_pat(input int i);
    case (i)
      0: return 23'h000000;
      1: return 23'h000001;
      2: return 23'h400000;
      3: return 23'h7fffff;
      4: return 23'h2aaaaa;
      default: return 23'h5c3e71;
    endcase
  endfunction

  task automatic apply_chk(input logic [31:0] r, input logic [31:0] g, input logic [31:0] b);
    in_red = r; in_green = g; in_blue = b; in_valid = 1'b1;
    @(negedge clk);
    cmp({31'd0, out_valid}, 32'd1, "R9");
    cmp({21'd0, out_word[10:0]},  32'(exp_code(r, 6)), tag_for(r, 6, "R1"));
    cmp({21'd0, out_word[21:11]}, 32'(exp_code(g, 6)), tag_for(g, 6, "R2"));
    cmp({22'd0, out_word[31:22]}, 32'(exp_code(b, 5)), tag_for(b, 5, "R3"));
  endtask

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    cmp({31'd0, out_valid}, 32'd0, "R9");
    cmp(out_word, 32'd0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    cmp({31'd0, out_valid}, 32'd0, "R9");

    // directed: 1.0 / +Inf / NaN
    in_red = 32'h3f800000; in_green = 32'h7f800000; in_blue = 32'h7fc00001;
    in_valid = 1'b1;
    @(negedge clk);
    cmp(out_word, 32'hfc3e03c0, "R1");

    // sweep
    for (int e8 = 0; e8 < 256; e8++) begin
      for (int mi = 0; mi < 6; mi++) begin
        for (int s = 0; s < 2; s++) begin
          logic [31:0] r, g, b;
          r = {s[0],  8'(e8),              man_pat(mi)};
          g = {~s[0], 8'((e8 + 37) % 256),  man_pat((mi + 2) % 6)};
          b = {s[0],  8'((e8 + 101) % 256), man_pat((mi + 4) % 6)};
          apply_chk(r, g, b);
          apply_chk(g, b, r);
          apply_chk(b, r, g);
        end
      end
    end

    // idle hold: R10
    held = out_word;
    in_valid = 1'b0;
    in_red = 32'h3f800000; in_green = 32'hbf800000; in_blue = 32'h00000000;
    @(negedge clk);
    cmp({31'd0, out_valid}, 32'd0, "R9");
    cmp(out_word, held, "R10");
    @(negedge clk);
    cmp(out_word, held, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule